// File: doc/BRIEF.md
# Windowed Display RAM Write Addresser

This block sits between a byte-serial pixel link and a packed display memory that holds 4-bit pixels, two per byte. The memory is 64 bytes wide and 80 rows deep. A byte strobe marks each pixel byte that arrives while the link is in data mode. The block writes that byte to the address set by its column and row pointers, then moves the pointers on inside a rectangular window. Software programs the window's column and row bounds.

A remap byte selects how the pointers move. With bit 2 clear they advance along a row first (horizontal). With bit 2 set they advance down a column first (vertical). The remaining remap bits are kept and shown at an output so that downstream display logic can use them; they have no effect on addressing. Every accepted byte sets a redraw-pending flag, and the display refresh side clears it.

Top module: `pixwin_writer`

## Requirements
- R1: After synchronous reset the column window is 0..63, the row window is 0..79, both pointers are 0, remap_cfg is 0, mem_we is 0 and redraw is 0.
- R2: A byte is accepted in a cycle where dat_valid=1 and win_load=0. On the next cycle mem_we=1, mem_wdata equals the byte and mem_addr = col + row*64, using the pointers from the accepted cycle. In every other cycle mem_we is 0 on the following cycle.
- R3: In horizontal mode (remap bit 2 = 0) the column advances by one after each byte. When it would pass the column upper bound it returns to the column lower bound and the row advances. A row that would pass the row upper bound returns to the row lower bound.
- R4: In vertical mode (remap bit 2 = 1) the row advances by one after each byte. When it would pass the row upper bound it returns to the row lower bound and the column advances. A column that would pass the column upper bound returns to the column lower bound.
- R5: win_load=1 captures the four bounds and, in the same cycle, sets the column pointer to the new column lower bound and the row pointer to the new row lower bound. A data byte offered in that cycle is dropped and produces no write.
- R6: A row bound of 80 or more is reduced modulo 80 when it is captured. Column bounds use all 6 bits.
- R7: remap_load=1 stores remap_val, and it appears on remap_cfg on the next cycle. Only bit 2 changes how addresses advance.
- R8: redraw becomes 1 together with each write. redraw_ack=1 clears it on the next cycle. If a byte is accepted in the same cycle as the clear, the flag stays 1.
- R9: Bytes may be accepted on every consecutive cycle. Each one is written exactly once, to the correct address, with no stall and no repeated address.
- R10: If a lower bound exceeds its upper bound, that pointer stays at the lower bound. The other pointer advances after every byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dat_valid | input | 1 | Pixel byte strobe (data mode) |
| dat_byte | input | 8 | Pixel byte, two 4-bit pixels |
| win_load | input | 1 | Capture window bounds and restart the pointers |
| col_lo | input | 6 | Column lower bound (byte column) |
| col_hi | input | 6 | Column upper bound |
| row_lo | input | 7 | Row lower bound, reduced modulo 80 |
| row_hi | input | 7 | Row upper bound, reduced modulo 80 |
| remap_load | input | 1 | Capture remap_val |
| remap_val | input | 8 | Remap byte; bit 2 selects vertical increment |
| redraw_ack | input | 1 | Clears the redraw flag |
| mem_we | output | 1 | Memory write enable (registered) |
| mem_addr | output | 13 | Memory byte address, col + row*64 |
| mem_wdata | output | 8 | Memory write data |
| redraw | output | 1 | Redraw pending flag |
| remap_cfg | output | 8 | Stored remap byte |

## Verification
A wrong pointer or a wrong wrap decision shows up on mem_addr on the very next write. From then on every later address in the stream is shifted, so one bad step is visible within one cycle and stays visible. The bench sweeps whole windows in both directions, including the corner at byte column 63 and row 79, inverted bounds and folded row bounds, and compares each address with one computed from the byte's index. A load that fails to drop the data byte offered with it shows as an extra write, and a redraw flag that is not set or not cleared shows directly on redraw.

// File: rtl/pw_pkg.sv
package pw_pkg;
  localparam int unsigned PW_COLS        = 64;
  localparam int unsigned PW_ROWS        = 80;
  localparam int unsigned PW_DW          = 8;
  localparam int unsigned REMAP_VERT_BIT = 2;

  typedef enum logic {DIR_HORIZ = 1'b0, DIR_VERT = 1'b1} dir_e;
endpackage

// File: rtl/pw_cfg_regs.sv
module pw_cfg_regs #(
  parameter int unsigned COLS = 64,
  parameter int unsigned ROWS = 80,
  parameter int unsigned CW   = 6,
  parameter int unsigned RW   = 7,
  parameter int unsigned DW   = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          win_load,
  input  logic [CW-1:0] col_lo,
  input  logic [CW-1:0] col_hi,
  input  logic [RW-1:0] row_lo,
  input  logic [RW-1:0] row_hi,
  input  logic          remap_load,
  input  logic [DW-1:0] remap_val,
  output logic [CW-1:0] ld_cs,
  output logic [RW-1:0] ld_rs,
  output logic [CW-1:0] cs,
  output logic [CW-1:0] ce,
  output logic [RW-1:0] rs,
  output logic [RW-1:0] re,
  output logic [DW-1:0] remap_q
);
  function automatic logic [CW-1:0] fold_col(input logic [CW-1:0] v);
    return CW'(32'(v) % COLS);
  endfunction

  function automatic logic [RW-1:0] fold_row(input logic [RW-1:0] v);
    return RW'(32'(v) % ROWS);
  endfunction

  assign ld_cs = fold_col(col_lo);
  assign ld_rs = fold_row(row_lo);

  always_ff @(posedge clk) begin
    if (rst) begin
      cs <= '0;
      ce <= CW'(COLS - 1);
      rs <= '0;
      re <= RW'(ROWS - 1);
    end else if (win_load) begin
      cs <= ld_cs;
      ce <= fold_col(col_hi);
      rs <= ld_rs;
      re <= fold_row(row_hi);
    end
  end

  always_ff @(posedge clk) begin
    if (rst)             remap_q <= '0;
    else if (remap_load) remap_q <= remap_val;
  end

  assert_row_bounds_folded_R6: assert property (@(posedge clk) disable iff (rst)
    (32'(rs) < ROWS) && (32'(re) < ROWS));
endmodule

// File: rtl/pw_ptr_step.sv
module pw_ptr_step
  import pw_pkg::*;
#(
  parameter int unsigned CW = 6,
  parameter int unsigned RW = 7
) (
  input  dir_e          dir,
  input  logic [CW-1:0] col,
  input  logic [RW-1:0] row,
  input  logic [CW-1:0] cs,
  input  logic [CW-1:0] ce,
  input  logic [RW-1:0] rs,
  input  logic [RW-1:0] re,
  output logic [CW-1:0] ncol,
  output logic [RW-1:0] nrow
);
  logic [CW:0] c_inc, c_tmp;
  logic [RW:0] r_inc, r_tmp;

  assign c_inc = {1'b0, col} + 1'b1;
  assign r_inc = {1'b0, row} + 1'b1;

  always_comb begin
    ncol  = col;
    nrow  = row;
    c_tmp = {1'b0, col};
    r_tmp = {1'b0, row};
    if (dir == DIR_HORIZ) begin
      if (c_inc > {1'b0, ce}) begin
        ncol  = cs;
        r_tmp = r_inc;
      end else begin
        ncol  = c_inc[CW-1:0];
      end
      nrow = (r_tmp > {1'b0, re}) ? rs : r_tmp[RW-1:0];
    end else begin
      if (r_inc > {1'b0, re}) begin
        nrow  = rs;
        c_tmp = c_inc;
      end else begin
        nrow  = r_inc[RW-1:0];
      end
      ncol = (c_tmp > {1'b0, ce}) ? cs : c_tmp[CW-1:0];
    end
  end
endmodule

// File: rtl/pw_wr_port.sv
module pw_wr_port #(
  parameter int unsigned COLS = 64,
  parameter int unsigned ROWS = 80,
  parameter int unsigned CW   = 6,
  parameter int unsigned RW   = 7,
  parameter int unsigned AW   = 13,
  parameter int unsigned DW   = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr,
  input  logic [CW-1:0] col,
  input  logic [RW-1:0] row,
  input  logic [DW-1:0] din,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata
);
  always_ff @(posedge clk) begin
    if (rst) mem_we <= 1'b0;
    else     mem_we <= wr;
  end

  always_ff @(posedge clk) begin
    if (wr) begin
      mem_addr  <= AW'(row) * AW'(COLS) + AW'(col);
      mem_wdata <= din;
    end
  end

  assert_addr_in_mem_R2: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (32'(mem_addr) < COLS * ROWS));
endmodule

// File: rtl/pixwin_writer.sv
module pixwin_writer
  import pw_pkg::*;
#(
  parameter int unsigned COLS = PW_COLS,
  parameter int unsigned ROWS = PW_ROWS,
  parameter int unsigned DW   = PW_DW,
  localparam int unsigned CW  = $clog2(COLS),
  localparam int unsigned RW  = $clog2(ROWS),
  localparam int unsigned AW  = $clog2(COLS * ROWS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          dat_valid,
  input  logic [DW-1:0] dat_byte,
  input  logic          win_load,
  input  logic [CW-1:0] col_lo,
  input  logic [CW-1:0] col_hi,
  input  logic [RW-1:0] row_lo,
  input  logic [RW-1:0] row_hi,
  input  logic          remap_load,
  input  logic [DW-1:0] remap_val,
  input  logic          redraw_ack,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          redraw,
  output logic [DW-1:0] remap_cfg
);
  logic [CW-1:0] cs, ce, ld_cs, col_q, col_n;
  logic [RW-1:0] rs, re, ld_rs, row_q, row_n;
  logic          accept;
  dir_e          dir;

  assign accept = dat_valid && !win_load;
  assign dir    = remap_cfg[REMAP_VERT_BIT] ? DIR_VERT : DIR_HORIZ;

  pw_cfg_regs #(.COLS(COLS), .ROWS(ROWS), .CW(CW), .RW(RW), .DW(DW)) u_cfg (
    .clk(clk), .rst(rst), .win_load(win_load),
    .col_lo(col_lo), .col_hi(col_hi), .row_lo(row_lo), .row_hi(row_hi),
    .remap_load(remap_load), .remap_val(remap_val),
    .ld_cs(ld_cs), .ld_rs(ld_rs),
    .cs(cs), .ce(ce), .rs(rs), .re(re), .remap_q(remap_cfg)
  );

  pw_ptr_step #(.CW(CW), .RW(RW)) u_step (
    .dir(dir), .col(col_q), .row(row_q),
    .cs(cs), .ce(ce), .rs(rs), .re(re),
    .ncol(col_n), .nrow(row_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      col_q <= '0;
      row_q <= '0;
    end else if (win_load) begin
      col_q <= ld_cs;
      row_q <= ld_rs;
    end else if (dat_valid) begin
      col_q <= col_n;
      row_q <= row_n;
    end
  end

  pw_wr_port #(.COLS(COLS), .ROWS(ROWS), .CW(CW), .RW(RW), .AW(AW), .DW(DW)) u_wr (
    .clk(clk), .rst(rst), .wr(accept), .col(col_q), .row(row_q), .din(dat_byte),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

  always_ff @(posedge clk) begin
    if (rst)             redraw <= 1'b0;
    else if (accept)     redraw <= 1'b1;
    else if (redraw_ack) redraw <= 1'b0;
  end

  assert_write_follows_R2: assert property (@(posedge clk) disable iff (rst)
    accept |=> (mem_we && mem_wdata == $past(dat_byte)));
  assert_no_stray_write_R2: assert property (@(posedge clk) disable iff (rst)
    !accept |=> !mem_we);
  assert_load_restart_R5: assert property (@(posedge clk) disable iff (rst)
    win_load |=> (col_q == $past(ld_cs) && row_q == $past(ld_rs)));
  assert_col_in_win_R3: assert property (@(posedge clk) disable iff (rst)
    (cs <= ce) |-> (col_q >= cs && col_q <= ce));
  assert_row_in_win_R4: assert property (@(posedge clk) disable iff (rst)
    (rs <= re) |-> (row_q >= rs && row_q <= re));
  assert_hstep_R3: assert property (@(posedge clk) disable iff (rst)
    (accept && dir == DIR_HORIZ && col_q < ce) |=>
      (col_q == $past(col_q) + 1'b1 && row_q == $past(row_q)));
  assert_vstep_R4: assert property (@(posedge clk) disable iff (rst)
    (accept && dir == DIR_VERT && row_q < re) |=>
      (row_q == $past(row_q) + 1'b1 && col_q == $past(col_q)));
  assert_redraw_with_write_R8: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> redraw);
endmodule

// File: tb/sim_pixwin_writer.sv
`timescale 1ns/1ps
module sim_pixwin_writer;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       dat_valid = 1'b0;
  logic [7:0] dat_byte = '0;
  logic       win_load = 1'b0;
  logic [5:0] col_lo = '0, col_hi = '0;
  logic [6:0] row_lo = '0, row_hi = '0;
  logic       remap_load = 1'b0;
  logic [7:0] remap_val = '0;
  logic       redraw_ack = 1'b0;
  logic        mem_we;
  logic [12:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic        redraw;
  logic [7:0]  remap_cfg;

  int checks = 0, errors = 0;
  int exp_cs = 0, exp_ce = 63, exp_rs = 0, exp_re = 79, exp_vert = 0;
  int wr_idx = 0, drv_idx = 0, cycles = 0;
  string tag = "R1";

  always #2.5 clk = ~clk;

  pixwin_writer u0 (
    .clk(clk), .rst(rst), .dat_valid(dat_valid), .dat_byte(dat_byte),
    .win_load(win_load), .col_lo(col_lo), .col_hi(col_hi),
    .row_lo(row_lo), .row_hi(row_hi), .remap_load(remap_load),
    .remap_val(remap_val), .redraw_ack(redraw_ack),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .redraw(redraw), .remap_cfg(remap_cfg)
  );

  function automatic int exp_addr(input int k);
    int w, h, idx, c, r;
    w = (exp_ce >= exp_cs) ? exp_ce - exp_cs + 1 : 1;
    h = (exp_re >= exp_rs) ? exp_re - exp_rs + 1 : 1;
    idx = k % (w * h);
    if (exp_vert != 0) begin
      c = exp_cs + idx / h;
      r = exp_rs + idx % h;
    end else begin
      r = exp_rs + idx / w;
      c = exp_cs + idx % w;
    end
    return c + r * 64;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && mem_we) begin
      check(int'(mem_addr) == exp_addr(wr_idx), tag, int'(mem_addr), exp_addr(wr_idx));
      check(mem_wdata == 8'((wr_idx ^ 8'h5A) & 8'hFF), "R2", int'(mem_wdata),
            (wr_idx ^ 8'h5A) & 8'hFF);
      wr_idx++;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic flush();
    repeat (3) @(negedge clk);
  endtask

  task automatic load_win(input int cl, input int ch, input int rl, input int rh);
    flush();
    @(negedge clk);
    win_load = 1'b1;
    col_lo = 6'(cl); col_hi = 6'(ch); row_lo = 7'(rl); row_hi = 7'(rh);
    exp_cs = cl; exp_ce = ch; exp_rs = rl % 80; exp_re = rh % 80;
    wr_idx = 0; drv_idx = 0;
    @(negedge clk);
    win_load = 1'b0;
  endtask

  task automatic set_remap(input logic [7:0] v);
    flush();
    @(negedge clk);
    remap_load = 1'b1; remap_val = v;
    @(negedge clk);
    remap_load = 1'b0;
    exp_vert = int'(v[2]);
    check(remap_cfg == v, "R7", int'(remap_cfg), int'(v));
  endtask

  task automatic burst(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      dat_valid = 1'b1;
      dat_byte = 8'((drv_idx ^ 8'h5A) & 8'hFF);
      drv_idx++;
    end
    @(negedge clk);
    dat_valid = 1'b0;
  endtask

  task automatic end_count(input int n, input string req);
    flush();
    check(wr_idx == n, req, wr_idx, n);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(mem_we == 1'b0, "R1", int'(mem_we), 0);
    check(redraw == 1'b0, "R1", int'(redraw), 0);
    check(remap_cfg == 8'h00, "R1", int'(remap_cfg), 0);

    // R1 / R3 / R9: reset window, full sweep plus wrap back to address 0
    tag = "R3";
    burst(5126);
    end_count(5126, "R9");
    check(redraw == 1'b1, "R8", int'(redraw), 1);

    // R3 small window horizontal
    load_win(8, 15, 10, 13);
    burst(37);
    end_count(37, "R3");

    // R4 vertical in the same window
    tag = "R4";
    set_remap(8'h04);
    load_win(8, 15, 10, 13);
    burst(37);
    end_count(37, "R4");
    // R4 vertical at the far corner columns 60..63, rows 0..79
    load_win(60, 63, 0, 79);
    burst(330);
    end_count(330, "R4");

    // R7 other remap bits do not change addressing
    tag = "R7";
    set_remap(8'hFB);
    load_win(1, 6, 70, 74);
    burst(33);
    end_count(33, "R7");

    // R6 row bounds folded modulo 80
    tag = "R6";
    load_win(0, 3, 85, 87);
    burst(14);
    end_count(14, "R6");

    // R10 inverted bounds, horizontal then vertical
    tag = "R10";
    load_win(10, 5, 3, 6);
    burst(9);
    end_count(9, "R10");
    set_remap(8'h04);
    load_win(2, 7, 9, 4);
    burst(8);
    end_count(8, "R10");
    set_remap(8'h00);

    // R5 load during a stream restarts pointers and drops the byte
    tag = "R5";
    load_win(4, 11, 2, 9);
    burst(13);
    @(negedge clk);
    win_load = 1'b1; dat_valid = 1'b1; dat_byte = 8'hEE;
    wr_idx = 0; drv_idx = 0;
    @(negedge clk);
    win_load = 1'b0; dat_valid = 1'b0;
    check(mem_we == 1'b0, "R5", int'(mem_we), 0);
    burst(20);
    end_count(20, "R5");

    // R8 redraw clear, and set winning over clear
    @(negedge clk);
    redraw_ack = 1'b1;
    @(negedge clk);
    redraw_ack = 1'b0;
    check(redraw == 1'b0, "R8", int'(redraw), 0);
    repeat (3) @(negedge clk);
    check(redraw == 1'b0, "R8", int'(redraw), 0);
    load_win(0, 63, 0, 79);
    @(negedge clk);
    redraw_ack = 1'b1; dat_valid = 1'b1;
    dat_byte = 8'((drv_idx ^ 8'h5A) & 8'hFF);
    drv_idx++;
    @(negedge clk);
    redraw_ack = 1'b0; dat_valid = 1'b0;
    check(redraw == 1'b1, "R8", int'(redraw), 1);
    end_count(1, "R8");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule